// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of external interrupt pins and turns activity on them into interrupt requests for a processor core. Each source has its own sense mode, enable bit and pending flag. Four sense modes are available: a level mode that requests while the pin is low, and three edge modes that latch a pending flag on any change, on a falling edge or on a rising edge. A request reaches the core only when both the source's enable bit and the global interrupt enable are set.

The pins are asynchronous. They pass through a two-flop synchroniser, and edges are found by comparing the synchronised sample with the one from the cycle before. Software programs one control register and one flag register through a simple write port. Latched flags are cleared when the core acknowledges the granted source, or when software writes a one to the flag bit. When several requests are active, the lowest-numbered source is granted.

Top module: `eisc_top`

## Requirements
- R1: After reset the control register, the flag register, every request line and the grant are all zero.
- R2: A write with `wr_addr_i`=0 loads the control register, and `ctrl_o` reads it back. With two sources, bit 0 enables source 0 and bit 1 enables source 1. Bits [3:2] hold the mode of source 0 and bits [5:4] the mode of source 1.
- R3: Mode code 00 is low level. The source requests while its synchronised pin is low, and the request follows the pin two clock edges after the pin changes. Its flag reads 0, and any flag latched earlier is discarded.
- R4: Mode code 01 latches the flag on any change of the pin. The flag reads 1 after the third rising clock edge following the change, and not before.
- R5: Mode code 10 latches the flag only on a falling edge of the pin.
- R6: Mode code 11 latches the flag only on a rising edge of the pin.
- R7: `irq_o[i]` is high only when enable bit i, `gie_i` and the source's pending condition are all high. A disabled source still latches its flag.
- R8: A write with `wr_addr_i`=1 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: `ack_i[i]` clears flag i only while source i is granted. An acknowledge to a source that is not granted has no effect.
- R10: `grant_o` is one-hot or zero, and it selects the lowest-indexed active request.
- R11: When an event is detected in the same cycle as a clear of that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_SRC | Raw external interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the control register, 1 selects the flag register |
| wr_data_i | input | 3*NUM_SRC | Write data |
| ack_i | input | NUM_SRC | Per-source vector acknowledge strobe |
| irq_o | output | NUM_SRC | Qualified request per source |
| grant_o | output | NUM_SRC | One-hot grant of the highest-priority request |
| ctrl_o | output | 3*NUM_SRC | Control register readback |
| flag_o | output | NUM_SRC | Pending flag readback |

## Verification
A wrong flag state shows on `flag_o` by the third edge after the pin event. It shows on `irq_o` and `grant_o` in the same cycle once the source is enabled. A synchroniser stage that is missing or extra moves the latency of the level request or of the flag by one cycle. The bench samples on both sides of that point, so such a fault is caught. A clear that hits the wrong flag, or an acknowledge that is not qualified by the grant, is visible on the very next readback.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] hist;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_i;
        sync_d.stable = sync_q.meta;
        sync_d.hist   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.stable;
    assign prev_o = sync_q.hist;
endmodule

// File: rtl/eisc_sense.sv
module eisc_sense
    import eisc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_i,
    input  logic   prev_i,
    input  sense_e mode_i,
    input  logic   clr_i,
    output logic   pend_o,
    output logic   flag_o
);
    typedef struct packed {
        logic flag;
    } sense_t;

    sense_t st_d, st_q;
    logic   evt;

    always_comb begin
        unique case (mode_i)
            SENSE_ANY:  evt = lvl_i ^ prev_i;
            SENSE_FALL: evt = prev_i & ~lvl_i;
            SENSE_RISE: evt = lvl_i & ~prev_i;
            default:    evt = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (mode_i == SENSE_LOW) st_d.flag = 1'b0;
        else if (evt)            st_d.flag = 1'b1;
        else if (clr_i)          st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = (mode_i == SENSE_LOW) ? ~lvl_i : st_q.flag;
    assign flag_o = (mode_i == SENSE_LOW) ? 1'b0   : st_q.flag;

    assert_level_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LOW) |=> !st_q.flag);
    assert_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_FALL && prev_i && !lvl_i) |=> st_q.flag);
    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_RISE && lvl_i && !prev_i) |=> st_q.flag);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (lvl_i == prev_i)) |=> !st_q.flag);
endmodule

// File: rtl/eisc_prio.sv
module eisc_prio #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] grant_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        assert_grant_onehot_R10: assert ($onehot0(grant_o));
        assert_grant_in_req_R10: assert ((grant_o & ~req_i) == '0);
    end
endmodule

// File: rtl/eisc_top.sv
module eisc_top
    import eisc_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     pin_i,
    input  logic                   gie_i,
    input  logic                   wr_en_i,
    input  logic                   wr_addr_i,
    input  logic [3*NUM_SRC-1:0]   wr_data_i,
    input  logic [NUM_SRC-1:0]     ack_i,
    output logic [NUM_SRC-1:0]     irq_o,
    output logic [NUM_SRC-1:0]     grant_o,
    output logic [3*NUM_SRC-1:0]   ctrl_o,
    output logic [NUM_SRC-1:0]     flag_o
);
    localparam int MODE_W = 2;
    localparam int CTRL_W = NUM_SRC * (1 + MODE_W);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_SRC-1:0] lvl, prev, pend, flags, clr, sw_clr, en;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && !wr_addr_i) regs_d.ctrl = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign en     = regs_q.ctrl[NUM_SRC-1:0];
    assign sw_clr = (wr_en_i && wr_addr_i) ? wr_data_i[NUM_SRC-1:0] : '0;

    eisc_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign clr[i] = sw_clr[i] | (ack_i[i] & grant_o[i]);

        eisc_sense u_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[i]),
            .prev_i (prev[i]),
            .mode_i (sense_e'(regs_q.ctrl[NUM_SRC + MODE_W*i +: MODE_W])),
            .clr_i  (clr[i]),
            .pend_o (pend[i]),
            .flag_o (flags[i])
        );

        assert_ack_other_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[i] && !grant_o[i] && flags[i] && !wr_en_i) |=> flags[i]);
    end

    assign irq_o  = en & pend & {NUM_SRC{gie_i}};
    assign ctrl_o = regs_q.ctrl;
    assign flag_o = flags;

    eisc_prio #(.WIDTH(NUM_SRC)) u_prio (
        .req_i   (irq_o),
        .grant_o (grant_o)
    );

    assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (irq_o == '0 && grant_o == '0));
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_addr_i) |=> (ctrl_o == $past(wr_data_i)));
endmodule

// File: tb/eisc_top_tb.sv
module eisc_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pins = 2'b00;
    logic       gie = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [5:0] wr_data = '0;
    logic [1:0] ack = 2'b00;
    logic [1:0] irq, grant, flag;
    logic [5:0] ctrl;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    eisc_top #(.NUM_SRC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .gie_i(gie),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ack_i(ack), .irq_o(irq), .grant_o(grant), .ctrl_o(ctrl), .flag_o(flag)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [5:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_ack(logic [1:0] a);
        ack = a;
        @(negedge clk);
        ack = 2'b00;
    endtask

    function automatic logic [5:0] mk(logic [1:0] m1, logic [1:0] m0, logic [1:0] en);
        return {m1, m0, en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 grant", grant, 0);

        // R2 control readback
        wr(1'b0, 6'b101101);
        chk("R2 ctrl readback", ctrl, 6'b101101);
        wr(1'b0, 6'b000000);
        chk("R2 ctrl cleared", ctrl, 0);

        // R3 low-level mode on source 0
        gie = 1'b1;
        wr(1'b0, mk(2'b00, 2'b00, 2'b01));
        chk("R3 low requests", irq[0], 1);
        pins[0] = 1'b1;
        wait_n(1);
        chk("R3 latency not yet", irq[0], 1);
        wait_n(1);
        chk("R3 high releases", irq[0], 0);
        chk("R3 flag reads zero", flag[0], 0);
        pins[0] = 1'b0;
        wait_n(2);
        chk("R3 low again", irq[0], 1);
        wr(1'b0, 6'b000000);

        // R4 R5 R6 R7 sweep: source, edge mode, starting level
        for (int s = 0; s < 2; s++) begin
            for (int m = 1; m < 4; m++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    logic [1:0] ms;
                    logic [1:0] ens;
                    int exp;
                    ms  = 2'(m);
                    ens = 2'b01 << s;
                    exp = (m == 1) || (m == 2 && lv == 1) || (m == 3 && lv == 0);
                    pins[s] = 1'(lv);
                    wait_n(4);
                    wr(1'b0, (s == 0) ? mk(2'b00, ms, 2'b00) : mk(ms, 2'b00, 2'b00));
                    wr(1'b1, 6'b000011);
                    pins[s] = ~1'(lv);
                    wait_n(2);
                    chk("R4 flag not before third edge", flag[s], 0);
                    wait_n(1);
                    chk((m == 1) ? "R4 any change" : (m == 2) ? "R5 falling" : "R6 rising",
                        flag[s], exp);
                    chk("R7 disabled no irq", irq, 0);
                    wr(1'b0, (s == 0) ? mk(2'b00, ms, ens) : mk(ms, 2'b00, ens));
                    chk("R7 enabled irq", irq[s], exp);
                    gie = 1'b0;
                    #1;
                    chk("R7 gie off", irq, 0);
                    gie = 1'b1;
                    wr(1'b0, 6'b000000);
                end
            end
        end

        // R8 write-one-to-clear, both sources rising mode
        pins = 2'b00;
        wr(1'b0, mk(2'b11, 2'b11, 2'b00));
        wait_n(4);
        wr(1'b1, 6'b000011);
        pins = 2'b11;
        wait_n(3);
        chk("R8 both set", flag, 2'b11);
        wr(1'b1, 6'b000001);
        chk("R8 clear bit0 only", flag, 2'b10);
        wr(1'b1, 6'b000000);
        chk("R8 zero write no effect", flag, 2'b10);
        wr(1'b1, 6'b000010);
        chk("R8 clear bit1", flag, 2'b00);

        // R9 R10 ack and priority
        pins = 2'b00;
        wait_n(4);
        pins = 2'b11;
        wait_n(3);
        wr(1'b0, mk(2'b11, 2'b11, 2'b11));
        chk("R10 both request", irq, 2'b11);
        chk("R10 lowest granted", grant, 2'b01);
        do_ack(2'b10);
        chk("R9 ack non-granted ignored", flag, 2'b11);
        do_ack(2'b01);
        chk("R9 ack clears granted", flag, 2'b10);
        chk("R10 grant moves", grant, 2'b10);
        do_ack(2'b10);
        chk("R9 ack second", flag, 2'b00);
        chk("R10 no grant", grant, 2'b00);

        // R11 event coincides with clear (flag0 currently 0: set it first)
        pins = 2'b00;
        wait_n(4);
        pins[0] = 1'b1;
        wait_n(3);
        chk("R11 precondition", flag[0], 1);
        pins[0] = 1'b0;
        wait_n(4);
        pins[0] = 1'b1;
        wait_n(2);
        wr(1'b1, 6'b000001);
        chk("R11 event wins over clear", flag[0], 1);
        wr(1'b1, 6'b000001);
        chk("R11 plain clear", flag[0], 0);

        // R3 switching to level mode discards a latched flag
        pins[0] = 1'b0;
        wait_n(4);
        pins[0] = 1'b1;
        wait_n(3);
        chk("R3 flag set before switch", flag[0], 1);
        wr(1'b0, mk(2'b11, 2'b00, 2'b00));
        chk("R3 level reads zero", flag[0], 0);
        wr(1'b0, mk(2'b11, 2'b11, 2'b00));
        chk("R3 flag discarded", flag[0], 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule